// File: doc/BRIEF.md
# Paged Isochronous Buffer Address Generator

This block turns a transaction record into a stream of physical byte addresses for an isochronous data buffer. The buffer may sit in up to seven separate 4 KB pages, and those pages need not be next to each other in memory. A table of seven page pointers is written through a simple load port. Only address bits 31 to 12 of each written word are kept, so the other fields that share that word never reach the address. A transaction start names the first page slot, a 12-bit byte offset inside that page and a byte length. From then on the block offers one address per data beat of four bytes.

The address stream uses a valid/ready handshake. A beat is consumed only in a cycle where `addr_valid` and `addr_ready` are both high. While `addr_valid` is high and `addr_ready` is low, `addr_out` holds its value, and it stays held for as many cycles as the stall lasts. `addr_valid` never waits on `addr_ready`. When the running offset passes the end of a page, the next beat takes the next slot of the pointer table, starting at offset zero. If the transfer would need a slot past the seventh, the block raises a sticky overrun flag and offers no more addresses until the next transaction start. The start, the pointer load and the overrun flag are plain level signals.

Top module: `iso_page_addr_gen`

## Requirements
- R1: After reset, `addr_valid` and `overrun_err` are both low.
- R2: `addr_out` is the stored bits 31..12 of the pointer in the current slot, followed by the 12-bit running offset. Bits 11..0 of a written pointer word never appear in `addr_out`.
- R3: In the cycle after `xfer_start` is high, `addr_valid` is high (if the length is non-zero) and `addr_out` is formed from `xfer_page` and `xfer_offset`.
- R4: Each accepted beat (valid and ready high together) adds 4 to the offset. While valid is high and ready is low, `addr_out` stays unchanged.
- R5: When adding 4 would carry out of bit 11, the offset becomes zero and the slot index rises by one. That slot's pointer is used as it was stored, with no arithmetic on the page number.
- R6: `addr_valid` stays high for exactly ceil(len/4) accepted beats and then goes low. A length of zero yields no beat.
- R7: A page crossing out of slot 6 with bytes still left sets `overrun_err`, which then stays high with `addr_valid` low until the next start. A transfer that ends exactly at the end of slot 6 sets no error.
- R8: A start whose page select is 7 sets `overrun_err` at once and produces no beat.
- R9: A start discards any transfer in progress, restarts from the new inputs and clears `overrun_err`.
- R10: A pointer write with index 7 changes no table entry.
- R11: Starting at offset 0x800 of slot 0, a 24576-byte transfer finishes within the seven slots without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_we | input | 1 | Write strobe for the pointer table |
| ptr_idx | input | 3 | Slot written (0..6; 7 ignored) |
| ptr_word | input | 32 | Pointer word; bits 31..12 are stored |
| xfer_start | input | 1 | Starts a transaction record |
| xfer_page | input | 3 | First slot of the transfer |
| xfer_offset | input | 12 | Byte offset in the first page |
| xfer_len | input | 15 | Transfer length in bytes |
| addr_ready | input | 1 | Consumer accepts the offered address |
| addr_valid | output | 1 | An address is offered |
| addr_out | output | 32 | Physical byte address of the current beat |
| overrun_err | output | 1 | Sticky: transfer ran past the last slot |

## Verification
A wrong slot index shows as a wrong upper address field on the first beat after a page crossing, within one cycle of the accepting handshake. A bad offset or a missed stall shows in the low twelve bits on the very next offered beat. A corrupted byte budget shows as `addr_valid` dropping one beat early or staying up one beat late at the end of the transfer. Wrong overrun logic shows up on the first cycle after the crossing out of the last slot, as a raised error or a still-offered address.

// File: rtl/iso_addr_pkg.sv
package iso_addr_pkg;
  localparam int unsigned DEF_ADDR_W     = 32;
  localparam int unsigned DEF_OFS_W      = 12;
  localparam int unsigned DEF_NUM_PTRS   = 7;
  localparam int unsigned DEF_BEAT_BYTES = 4;
  localparam int unsigned DEF_LEN_W      = 15;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FAULT
  } walk_state_e;
endpackage

// File: rtl/iso_ptr_table.sv
module iso_ptr_table #(
  parameter int unsigned NUM_PTRS = iso_addr_pkg::DEF_NUM_PTRS,
  parameter int unsigned ADDR_W   = iso_addr_pkg::DEF_ADDR_W,
  parameter int unsigned OFS_W    = iso_addr_pkg::DEF_OFS_W,
  localparam int unsigned SEL_W   = $clog2(NUM_PTRS + 1),
  localparam int unsigned PAGE_W  = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_word,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [PAGE_W-1:0] rd_page
);
  logic [NUM_PTRS-1:0][PAGE_W-1:0] pages;

  // One register per slot; only the page field of the word is kept.
  for (genvar g = 0; g < NUM_PTRS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pages[g] <= '0;
      end else if (wr_en && (wr_idx == SEL_W'(g))) begin
        pages[g] <= wr_word[ADDR_W-1:OFS_W];
      end
    end
  end

  always_comb begin
    rd_page = '0;
    if (rd_sel < SEL_W'(NUM_PTRS)) rd_page = pages[rd_sel];
  end

  // An out-of-range write index leaves every slot untouched (R10).
  p_bad_idx_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx >= SEL_W'(NUM_PTRS))) |=> $stable(pages));
endmodule

// File: rtl/iso_beat_budget.sv
module iso_beat_budget #(
  parameter int unsigned LEN_W      = iso_addr_pkg::DEF_LEN_W,
  parameter int unsigned BEAT_BYTES = iso_addr_pkg::DEF_BEAT_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             consume,
  output logic             empty,
  output logic             final_beat
);
  logic [LEN_W-1:0] remain;

  assign empty      = (remain == '0);
  assign final_beat = (remain <= LEN_W'(BEAT_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_len;
    end else if (consume && !empty) begin
      remain <= final_beat ? '0 : remain - LEN_W'(BEAT_BYTES);
    end
  end

  // The budget only shrinks between loads (R6).
  p_budget_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> remain <= $past(remain));
endmodule

// File: rtl/iso_offset_walker.sv
module iso_offset_walker #(
  parameter int unsigned NUM_PTRS   = iso_addr_pkg::DEF_NUM_PTRS,
  parameter int unsigned OFS_W      = iso_addr_pkg::DEF_OFS_W,
  parameter int unsigned BEAT_BYTES = iso_addr_pkg::DEF_BEAT_BYTES,
  localparam int unsigned SEL_W     = $clog2(NUM_PTRS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] load_sel,
  input  logic [OFS_W-1:0] load_ofs,
  input  logic             step,
  input  logic             step_is_last,
  input  logic             budget_empty,
  output logic [SEL_W-1:0] sel,
  output logic [OFS_W-1:0] ofs,
  output logic             live,
  output logic             fault
);
  import iso_addr_pkg::*;

  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_PTRS - 1);

  walk_state_e      state;
  logic [OFS_W:0]   ofs_sum;
  logic             carry;

  assign ofs_sum = {1'b0, ofs} + (OFS_W + 1)'(BEAT_BYTES);
  assign carry   = ofs_sum[OFS_W];
  assign fault   = (state == ST_FAULT);
  assign live    = (state == ST_RUN) && !budget_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sel   <= '0;
      ofs   <= '0;
    end else if (load) begin
      sel   <= load_sel;
      ofs   <= load_ofs;
      state <= (load_sel > LAST_SEL) ? ST_FAULT : ST_RUN;
    end else if (step && live) begin
      if (!carry) begin
        ofs <= ofs_sum[OFS_W-1:0];
      end else begin
        ofs <= '0;
        if (!step_is_last) begin
          if (sel == LAST_SEL) state <= ST_FAULT;
          else                 sel   <= sel + SEL_W'(1);
        end
      end
    end
  end

  // A fault hides the stream (R7).
  p_no_beat_in_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !live);
  // A fault persists until the next load (R7).
  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !load) |=> fault);
  // A non-carrying step moves the offset by one beat (R4).
  p_step_adds_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && live && !load && !carry) |=>
      (ofs == $past(ofs) + OFS_W'(BEAT_BYTES)) && (sel == $past(sel)));
  // A carrying step with data left either moves one slot on at offset zero or faults (R5).
  p_cross_next_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && live && !load && carry && !step_is_last) |=>
      (ofs == '0) && ((sel == $past(sel) + SEL_W'(1)) || fault));
  // An offered beat always points into the table (R5).
  p_sel_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (sel <= LAST_SEL));
endmodule

// File: rtl/iso_page_addr_gen.sv
module iso_page_addr_gen #(
  parameter int unsigned NUM_PTRS   = iso_addr_pkg::DEF_NUM_PTRS,
  parameter int unsigned ADDR_W     = iso_addr_pkg::DEF_ADDR_W,
  parameter int unsigned OFS_W      = iso_addr_pkg::DEF_OFS_W,
  parameter int unsigned BEAT_BYTES = iso_addr_pkg::DEF_BEAT_BYTES,
  parameter int unsigned LEN_W      = iso_addr_pkg::DEF_LEN_W,
  localparam int unsigned SEL_W     = $clog2(NUM_PTRS + 1),
  localparam int unsigned PAGE_W    = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_we,
  input  logic [SEL_W-1:0]  ptr_idx,
  input  logic [ADDR_W-1:0] ptr_word,
  input  logic              xfer_start,
  input  logic [SEL_W-1:0]  xfer_page,
  input  logic [OFS_W-1:0]  xfer_offset,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              addr_ready,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr_out,
  output logic              overrun_err
);
  logic [SEL_W-1:0]  cur_sel;
  logic [OFS_W-1:0]  cur_ofs;
  logic [PAGE_W-1:0] cur_page;
  logic              handshake;
  logic              budget_empty;
  logic              budget_final;
  logic              walk_live;

  assign addr_valid = walk_live;
  assign handshake  = addr_valid && addr_ready;
  assign addr_out   = {cur_page, cur_ofs};

  iso_ptr_table #(
    .NUM_PTRS(NUM_PTRS), .ADDR_W(ADDR_W), .OFS_W(OFS_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ptr_we), .wr_idx(ptr_idx), .wr_word(ptr_word),
    .rd_sel(cur_sel), .rd_page(cur_page)
  );

  iso_beat_budget #(
    .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)
  ) u_budget (
    .clk(clk), .rst_n(rst_n),
    .load(xfer_start), .load_len(xfer_len),
    .consume(handshake),
    .empty(budget_empty), .final_beat(budget_final)
  );

  iso_offset_walker #(
    .NUM_PTRS(NUM_PTRS), .OFS_W(OFS_W), .BEAT_BYTES(BEAT_BYTES)
  ) u_walker (
    .clk(clk), .rst_n(rst_n),
    .load(xfer_start), .load_sel(xfer_page), .load_ofs(xfer_offset),
    .step(handshake), .step_is_last(budget_final), .budget_empty(budget_empty),
    .sel(cur_sel), .ofs(cur_ofs), .live(walk_live), .fault(overrun_err)
  );

  // Reset leaves the port quiet (R1).
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!addr_valid && !overrun_err));
  // Back-pressure holds the offered address (R4).
  p_stall_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready && !xfer_start && !ptr_we) |=>
      (addr_valid && $stable(addr_out)));
  // A start always clears a previous overrun unless its page is out of range (R9).
  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && (xfer_page < SEL_W'(NUM_PTRS))) |=> !overrun_err);
  // An out-of-range start page faults at once (R8).
  p_bad_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && (xfer_page >= SEL_W'(NUM_PTRS))) |=> (overrun_err && !addr_valid));
endmodule

// File: tb/iso_page_addr_gen_tb.sv
module iso_page_addr_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ptr_we;
  logic [2:0]  ptr_idx;
  logic [31:0] ptr_word;
  logic        xfer_start;
  logic [2:0]  xfer_page;
  logic [11:0] xfer_offset;
  logic [14:0] xfer_len;
  logic        addr_ready;
  logic        addr_valid;
  logic [31:0] addr_out;
  logic        overrun_err;

  int n_chk  = 0;
  int n_fail = 0;
  logic [19:0] pg [0:6];

  always #(CLK_PERIOD/2) clk = ~clk;

  iso_page_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n),
    .ptr_we(ptr_we), .ptr_idx(ptr_idx), .ptr_word(ptr_word),
    .xfer_start(xfer_start), .xfer_page(xfer_page),
    .xfer_offset(xfer_offset), .xfer_len(xfer_len),
    .addr_ready(addr_ready), .addr_valid(addr_valid),
    .addr_out(addr_out), .overrun_err(overrun_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_ptr(input int idx, input logic [31:0] word);
    @(negedge clk);
    ptr_we = 1'b1; ptr_idx = 3'(idx); ptr_word = word;
    @(negedge clk);
    ptr_we = 1'b0;
  endtask

  // Starts a record and follows it with a bench-side model of R3..R8.
  // stall_mod > 0 drops ready every stall_mod-th cycle; max_cyc bounds the walk.
  task automatic run_xfer(input string req, input int page, input int ofs, input int len,
                          input int stall_mod, input int max_cyc, input bit exp_err_end);
    int s = page;
    int o = ofs;
    int r = len;
    bit e = (page > 6);
    bit ev;
    int cyc = 0;
    @(negedge clk);
    xfer_start = 1'b1; xfer_page = 3'(page); xfer_offset = 12'(ofs); xfer_len = 15'(len);
    addr_ready = 1'b0;
    @(negedge clk);
    xfer_start = 1'b0;
    forever begin
      addr_ready = (stall_mod == 0) ? 1'b1 : ((cyc % stall_mod) != 0);
      #1;
      ev = (r > 0) && !e;
      chk(addr_valid == ev, {req, " valid"}, 32'(addr_valid), 32'(ev));
      if (ev) chk(addr_out == {pg[s], 12'(o)}, {req, " addr"}, addr_out, {pg[s], 12'(o)});
      chk(overrun_err == e, {req, " err"}, 32'(overrun_err), 32'(e));
      if (!ev || cyc >= max_cyc) break;
      if (addr_ready) begin
        r = (r > 4) ? r - 4 : 0;
        if (o + 4 >= 4096) begin
          o = 0;
          if (r > 0) begin
            if (s == 6) e = 1'b1;
            else s++;
          end
        end else begin
          o += 4;
        end
      end
      cyc++;
      @(negedge clk);
    end
    addr_ready = 1'b0;
    if (cyc < max_cyc) chk(overrun_err == exp_err_end, {req, " final err"}, 32'(overrun_err), 32'(exp_err_end));
  endtask

  task automatic t_reset;
    chk(addr_valid == 1'b0, "R1 valid after reset", 32'(addr_valid), 0);
    chk(overrun_err == 1'b0, "R1 err after reset", 32'(overrun_err), 0);
  endtask

  task automatic t_basic;
    run_xfer("R3 R2 short", 2, 12'h040, 16, 0, 1000, 1'b0);
    run_xfer("R6 odd len", 4, 12'h100, 7, 0, 1000, 1'b0);
    run_xfer("R6 zero len", 1, 0, 0, 0, 1000, 1'b0);
  endtask

  task automatic t_stall;
    run_xfer("R4 stall", 3, 12'hFE0, 80, 3, 1000, 1'b0);
  endtask

  task automatic t_cross;
    run_xfer("R5 cross", 0, 12'hFF0, 64, 0, 1000, 1'b0);
    run_xfer("R5 unaligned", 1, 12'hFFE, 12, 2, 1000, 1'b0);
  endtask

  task automatic t_overrun;
    run_xfer("R7 overrun", 5, 12'hFF8, 4096 + 16, 0, 5000, 1'b1);
    repeat (3) @(negedge clk);
    #1;
    chk(overrun_err == 1'b1, "R7 sticky err", 32'(overrun_err), 1);
    chk(addr_valid == 1'b0, "R7 no beat after err", 32'(addr_valid), 0);
    run_xfer("R7 exact end", 6, 0, 4096, 0, 5000, 1'b0);
  endtask

  task automatic t_bad_page;
    run_xfer("R8 page7", 7, 0, 32, 0, 1000, 1'b1);
    run_xfer("R9 clear after err", 2, 12'h010, 8, 0, 1000, 1'b0);
  endtask

  task automatic t_restart;
    run_xfer("R9 first", 0, 0, 64, 0, 3, 1'b0);
    run_xfer("R9 restart", 5, 12'h200, 12, 0, 1000, 1'b0);
  endtask

  task automatic t_ptr_write;
    write_ptr(7, 32'hFFFF_FABC);
    run_xfer("R10 idx7 ignored", 6, 12'h020, 8, 0, 1000, 1'b0);
    pg[3] = 20'h5_1F00;
    write_ptr(3, {pg[3], 12'hABC});
    run_xfer("R2 rewritten ptr", 3, 12'h004, 8, 0, 1000, 1'b0);
  endtask

  task automatic t_full;
    run_xfer("R11 full 24576", 0, 12'h800, 24576, 0, 10000, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; ptr_we = 1'b0; ptr_idx = '0; ptr_word = '0;
    xfer_start = 1'b0; xfer_page = '0; xfer_offset = '0; xfer_len = '0;
    addr_ready = 1'b0;
    for (int i = 0; i < 7; i++) pg[i] = 20'h8_0000 + 20'((6 - i) * 20'h113) + 20'(i * 20'h4000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    t_reset();
    for (int i = 0; i < 7; i++) write_ptr(i, {pg[i], 12'(12'hF0F ^ 12'(i))});
    t_basic();
    t_stall();
    t_cross();
    t_overrun();
    t_bad_page();
    t_restart();
    t_ptr_write();
    t_full();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule